// File: doc/BRIEF.md
# Serial Clock Prescaler

This block derives a serial bus clock from the parent clock it runs on. A 16-bit select word holds two fields that work in cascade. A lower power-of-two field sets a base ratio. An upper prescale field can multiply that base by 32. One code of the lower field bypasses division altogether. Together the fields cover ratios from 1 to 1024.

The block drives three registered outputs:
- a toggling serial clock that rests at a programmable idle level;
- a strobe that marks every serial-clock edge, so shift logic can launch or capture on either edge;
- a strobe that marks each completed serial-clock period.

A `run` input starts and stops generation. While `run` is low the counters restart and the clock rests at its idle level. The select word and the polarity are changed only while stopped.

Timing model: `run` is sampled at a clock edge, and that edge is sample 1. For a half period of H parent cycles, the edge strobe is high at samples H, 2H, 3H and so on. At sample i the serial clock equals `cpol` XOR (floor(i/H) mod 2).

Top module: `sclk_prescaler`

## Requirements
- R1: Only `div_sel[2:0]` (lower field) and `div_sel[12:8]` (upper field) affect behaviour. Bits 15:13 and 7:3 are ignored.
- R2: With the upper field at 0 and a lower code n from 0 to 4, the half period is 2^n parent cycles, so the ratio is 2^(n+1).
- R3: With the upper field at 0x1F and a lower code n from 0 to 4, the half period is 2^(n+5) cycles, giving ratios 64 to 1024.
- R4: Lower code 7 selects bypass, whatever the upper field holds. While running in bypass, `edge_stb` and `period_stb` are high every cycle and `sck` toggles every cycle.
- R5: Upper-field values other than 0 and 0x1F behave exactly like 0.
- R6: Lower codes 5 and 6 behave like code 4.
- R7: When `run` is sampled low, the next cycle shows `sck` equal to the sampled `cpol`, with both strobes low. Generation restarts from a zero count, so the first `edge_stb` comes exactly one half period after `run` is sampled high again.
- R8: While running, `sck` changes only in a cycle that shows `edge_stb` high, and every such cycle shows a change.
- R9: `period_stb` is high only together with `edge_stb`. Outside bypass, it marks the edge that returns `sck` to the idle level, once every two half periods.
- R10: While `rst` is applied, `sck`, `edge_stb` and `period_stb` are all 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parent clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables serial-clock generation |
| cpol | input | 1 | Idle level of `sck` |
| div_sel | input | 16 | Divider select word: lower field [2:0], upper field [12:8] |
| sck | output | 1 | Serial clock, registered |
| edge_stb | output | 1 | One-cycle pulse for each `sck` edge |
| period_stb | output | 1 | One-cycle pulse for each completed `sck` period |

## Verification
The assertions check the cycle-local rules on every cycle:
- the idle level and quiet strobes after a stop;
- that `sck` changes exactly when `edge_stb` is high;
- that `period_stb` only comes with an edge and lands on the idle level;
- that the stage counters return to zero.

The actual ratio from each select code cannot be seen from one cycle. The same holds for the mapping of reserved and ignored bits, the bypass rate and the alignment of the first edge after a restart. The bench shows these by following whole waveforms for each select value in its table and in directed stop, restart and reset scenarios.

// File: rtl/sclk_prescaler_pkg.sv
package sclk_prescaler_pkg;
  localparam int SEL_W       = 16;
  localparam int LO_W        = 3;
  localparam int UP_W        = 5;
  localparam int UP_LSB      = 8;
  localparam int CODE_MAX    = 4;   // largest plain power-of-two code
  localparam int CODE_BYPASS = 7;   // lower-field code for divide-by-1
  localparam int UP_MUL_CODE = 31;  // upper-field value selecting x32
  localparam int MUL_LOG2    = 5;   // log2 of the upper-field multiplier

  typedef struct packed {
    logic            bypass;
    logic [LO_W-1:0] shift;
    logic            mul_en;
  } sclk_cfg_t;
endpackage

// File: rtl/sclk_sel_decode.sv
module sclk_sel_decode
  import sclk_prescaler_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output sclk_cfg_t        cfg
);
  logic [LO_W-1:0] lo;
  logic [UP_W-1:0] up;

  assign lo = sel[LO_W-1:0];
  assign up = sel[UP_LSB +: UP_W];

  always_comb begin
    cfg.bypass = (lo == LO_W'(CODE_BYPASS));
    if (cfg.bypass)
      cfg.shift = '0;
    else if (lo > LO_W'(CODE_MAX))
      cfg.shift = LO_W'(CODE_MAX);
    else
      cfg.shift = lo;
    cfg.mul_en = !cfg.bypass && (up == UP_W'(UP_MUL_CODE));
  end
endmodule

// File: rtl/sclk_pow2_stage.sv
module sclk_pow2_stage #(
  parameter int SHIFT_MAX = 4,
  parameter int SHIFT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int CW = (SHIFT_MAX > 0) ? SHIFT_MAX : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = ~({CW{1'b1}} << shift);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  // R7: a stop clears the base counter
  p_base_restart_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));
endmodule

// File: rtl/sclk_mul_stage.sv
module sclk_mul_stage #(
  parameter int MUL_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic en,
  input  logic tick_in,
  output logic tick_out
);
  generate
    if (MUL_LOG2 > 0) begin : g_mul
      logic [MUL_LOG2-1:0] cnt;

      assign tick_out = tick_in && (!en || (&cnt));

      always_ff @(posedge clk) begin
        if (rst || !run)
          cnt <= '0;
        else if (tick_in && en)
          cnt <= cnt + 1'b1;
      end

      // R7: a stop clears the multiplier counter
      p_mul_restart_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));
    end else begin : g_pass
      assign tick_out = tick_in;
    end
  endgenerate
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclk_prescaler_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             cpol,
  input  logic [SEL_W-1:0] div_sel,
  output logic             sck,
  output logic             edge_stb,
  output logic             period_stb
);
  sclk_cfg_t cfg;
  logic      tick_a;
  logic      tick_b;

  sclk_sel_decode u_decode (
    .sel (div_sel),
    .cfg (cfg)
  );

  sclk_pow2_stage #(
    .SHIFT_MAX (CODE_MAX),
    .SHIFT_W   (LO_W)
  ) u_base (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .shift (cfg.shift),
    .tick  (tick_a)
  );

  sclk_mul_stage #(
    .MUL_LOG2 (MUL_LOG2)
  ) u_mul (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .en       (cfg.mul_en),
    .tick_in  (tick_a),
    .tick_out (tick_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sck        <= 1'b0;
      edge_stb   <= 1'b0;
      period_stb <= 1'b0;
    end else begin
      edge_stb   <= tick_b;
      period_stb <= tick_b && (cfg.bypass || (sck != cpol));
      if (!run)
        sck <= cpol;
      else if (tick_b)
        sck <= ~sck;
    end
  end

  // R7: stopped output rests at the idle level with quiet strobes
  p_idle_level_r7: assert property (@(posedge clk) disable iff (rst)
    !run |=> (sck == $past(cpol)) && !edge_stb && !period_stb);

  // R8: every marked edge is a real change of sck
  p_edge_toggles_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && edge_stb) |-> (sck != $past(sck)));

  // R8: no change of sck while running without a marked edge
  p_hold_between_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run) && !edge_stb) |-> $stable(sck));

  // R9: period strobe only together with an edge
  p_period_on_edge_r9: assert property (@(posedge clk) disable iff (rst)
    period_stb |-> edge_stb);

  // R9: outside bypass the period strobe lands on the idle level
  p_period_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && period_stb && !$past(cfg.bypass)) |-> (sck == $past(cpol)));
endmodule

// File: tb/sclk_prescaler_bench.sv
module sclk_prescaler_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        run;
  logic        cpol;
  logic [15:0] div_sel;
  logic        sck;
  logic        edge_stb;
  logic        period_stb;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;

  always #4 clk = ~clk;  // 125 MHz

  sclk_prescaler u_sclk_prescaler (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .cpol       (cpol),
    .div_sel    (div_sel),
    .sck        (sck),
    .edge_stb   (edge_stb),
    .period_stb (period_stb)
  );

  // Vector table: select word, idle level, half period (0 = bypass), requirement
  localparam int NV = 16;
  localparam logic [15:0] V_SEL [NV] = '{
    16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004,   // R2
    16'h1F00, 16'h1F02, 16'h1F04,                       // R3
    16'h0007, 16'h1F07,                                 // R4
    16'h0A02, 16'h1E00,                                 // R5
    16'h0005, 16'h0006,                                 // R6
    16'hE0F3, 16'h3F01                                  // R1
  };
  localparam logic V_POL [NV] = '{
    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1
  };
  localparam int V_HALF [NV] = '{
    1, 2, 4, 8, 16, 32, 128, 512, 0, 0, 4, 1, 16, 16, 8, 64
  };
  localparam int V_REQ [NV] = '{
    2, 2, 2, 2, 2, 3, 3, 3, 4, 4, 5, 5, 6, 6, 1, 1
  };

  task automatic check(input bit ok, input string req, input logic [2:0] act,
                       input logic [2:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s sck/edge/period actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; run = 1'b0; cpol = 1'b1; div_sel = 16'h0000;
    repeat (3) @(negedge clk);
    // R10: reset state
    check({sck, edge_stb, period_stb} == 3'b000, "R10 reset",
          {sck, edge_stb, period_stb}, 3'b000);
    rst = 1'b0;

    // Table walk: R1..R6, with R8 and R9 checked on every sample
    for (int v = 0; v < NV; v++) begin
      int h;
      int n;
      int bad;
      logic [2:0] act_s;
      logic [2:0] exp_s;
      h = V_HALF[v];
      run = 1'b0; div_sel = V_SEL[v]; cpol = V_POL[v];
      @(negedge clk);
      @(negedge clk);
      run = 1'b1;
      n = (h == 0) ? 8 : 4 * h;
      bad = 0;
      act_s = '0; exp_s = '0;
      for (int i = 1; i <= n; i++) begin
        logic [2:0] e;
        @(negedge clk);
        if (h == 0)
          e = {V_POL[v] ^ i[0], 1'b1, 1'b1};
        else
          e = {V_POL[v] ^ (((i / h) % 2) == 1), (i % h) == 0, (i % (2 * h)) == 0};
        if ({sck, edge_stb, period_stb} !== e) begin
          if (bad == 0) begin
            act_s = {sck, edge_stb, period_stb};
            exp_s = e;
          end
          bad++;
        end
      end
      check(bad == 0, $sformatf("R%0d (with R8 R9) sel=%h", V_REQ[v], V_SEL[v]),
            act_s, exp_s);
    end

    // R7: stop in the middle of a period
    run = 1'b0; div_sel = 16'h0002; cpol = 1'b1;
    @(negedge clk);
    run = 1'b1;
    repeat (6) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check({sck, edge_stb, period_stb} == 3'b100, "R7 stop idle level",
          {sck, edge_stb, period_stb}, 3'b100);
    begin
      int moved;
      moved = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if ({sck, edge_stb, period_stb} != 3'b100) moved++;
      end
      check(moved == 0, "R7 held while stopped",
            {sck, edge_stb, period_stb}, 3'b100);
    end

    // R7: polarity change while stopped shows after one edge
    cpol = 1'b0;
    @(negedge clk);
    check({sck, edge_stb, period_stb} == 3'b000, "R7 polarity follow",
          {sck, edge_stb, period_stb}, 3'b000);

    // R7: restart gives the first edge exactly one half period (4) later
    run = 1'b1;
    begin
      int early;
      early = 0;
      for (int i = 1; i <= 3; i++) begin
        @(negedge clk);
        if (edge_stb || sck) early++;
      end
      check(early == 0, "R7 no early edge after restart",
            {sck, edge_stb, period_stb}, 3'b000);
    end
    @(negedge clk);
    check({sck, edge_stb, period_stb} == 3'b110, "R7 first edge after restart",
          {sck, edge_stb, period_stb}, 3'b110);

    // R10: reset while running clears all outputs
    rst = 1'b1;
    @(negedge clk);
    check({sck, edge_stb, period_stb} == 3'b000, "R10 reset while running",
          {sck, edge_stb, period_stb}, 3'b000);
    rst = 1'b0; run = 1'b0;
    @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule